// File: doc/BRIEF.md
# Split Divide-by-Two / Divide-by-Five Decade Counter

A four-bit counter made of two separable sections: a one-bit divide-by-two stage and a three-bit divide-by-five stage. Each section has its own count-enable input, so the two can run as independent dividers. A chain control ties them together into a decade counter. In that mode the five-state section advances each time the one-bit stage wraps from 1 back to 0, and the four outputs then read as a BCD digit from 0 to 9.

Two paired controls override counting. Clearing takes effect only when both clear inputs are high. Presetting to nine takes effect only when both preset inputs are high. Both act on the clock edge, like every other update in the block. A separate active-high synchronous reset returns the block to zero.

Top module: `dec_split_counter`

## Requirements
- R1: While `rst` is high at a rising edge, all state goes to zero: `q_lo`=0, `q_hi`=0, `bcd`=0. `rst` overrides every other input.
- R2: The one-bit stage inverts `q_lo` on each edge where `en_lo` is high and holds its value when `en_lo` is low.
- R3: With `chain`=0, the three-bit stage advances on each edge where `en_hi` is high. It steps through 0,1,2,3,4 and then returns to 0. `en_lo` does not affect it.
- R4: With `chain`=1, the three-bit stage advances exactly on edges where `en_lo` is high and `q_lo` is 1, and `en_hi` is ignored. Starting from zero, `bcd` then runs 0 through 9 and back to 0.
- R5: Clearing to zero requires both `clr_a` and `clr_b` high. Either one alone changes nothing.
- R6: Presetting requires both `set9_a` and `set9_b` high. Either one alone changes nothing. A preset gives `bcd`=4'b1001, which is `q_lo`=1 and `q_hi`=3'b100.
- R7: When both presets and both clears are high together, the preset wins and the result is nine.
- R8: A clear or preset takes effect regardless of `en_lo`, `en_hi` and `chain`.
- R9: `q_hi` never holds a value above 4.
- R10: `bcd` is `{q_hi, q_lo}`. Bit 0 is the one-bit stage, and bits 3:1 are the three-bit stage with its most significant bit at bit 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state updates on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| en_lo | input | 1 | Count enable of the divide-by-two stage |
| en_hi | input | 1 | Count enable of the divide-by-five stage when not chained |
| chain | input | 1 | 1 = five-state stage driven by the wrap of the one-bit stage |
| clr_a | input | 1 | Clear request, first of the pair |
| clr_b | input | 1 | Clear request, second of the pair |
| set9_a | input | 1 | Preset-to-nine request, first of the pair |
| set9_b | input | 1 | Preset-to-nine request, second of the pair |
| q_lo | output | 1 | Divide-by-two stage output |
| q_hi | output | 3 | Divide-by-five stage output, 0..4 |
| bcd | output | 4 | Combined digit `{q_hi, q_lo}` |

## Verification
Every control and enable takes effect one rising edge after it is presented, because the outputs come straight from the stage registers and nothing lies in between. In chained mode the carry into the upper stage uses the same edge as the toggle of the lower stage, so no extra cycle is spent on it. The bench changes inputs on the falling edge. It advances its reference model at the following rising edge and compares all outputs a moment after that edge, once per cycle. Each comparison is tagged with the requirement that the current stimulus phase exercises.

// File: rtl/dec_split_pkg.sv
package dec_split_pkg;
  parameter int unsigned LO_MOD = 2;
  parameter int unsigned HI_MOD = 5;
  localparam int unsigned LO_W = (LO_MOD > 1) ? $clog2(LO_MOD) : 1;
  localparam int unsigned HI_W = (HI_MOD > 1) ? $clog2(HI_MOD) : 1;
  localparam int unsigned OUT_W = LO_W + HI_W;

  typedef struct packed {
    logic load;
    logic clear;
    logic step_lo;
    logic step_hi;
  } stage_ctl_t;
endpackage

// File: rtl/dec_split_ctrl.sv
module dec_split_ctrl #(
  parameter int unsigned LO_W = 1,
  parameter int unsigned LO_MOD = 2
) (
  input  logic                    en_lo,
  input  logic                    en_hi,
  input  logic                    chain,
  input  logic                    clr_a,
  input  logic                    clr_b,
  input  logic                    set9_a,
  input  logic                    set9_b,
  input  logic [LO_W-1:0]         q_lo,
  output dec_split_pkg::stage_ctl_t ctl
);
  localparam logic [LO_W-1:0] LO_LAST = LO_W'(LO_MOD - 1);

  logic lo_wraps;

  always_comb begin
    lo_wraps     = en_lo && (q_lo == LO_LAST);
    ctl.load     = set9_a && set9_b;
    ctl.clear    = clr_a && clr_b && !(set9_a && set9_b);
    ctl.step_lo  = en_lo;
    ctl.step_hi  = chain ? lo_wraps : en_hi;
  end
endmodule

// File: rtl/dec_split_stage.sv
module dec_split_stage #(
  parameter int unsigned W = 3,
  parameter int unsigned MOD = 5,
  parameter int unsigned LOAD_VAL = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         clear,
  input  logic         step,
  output logic [W-1:0] q
);
  localparam logic [W-1:0] LAST = W'(MOD - 1);
  localparam logic [W-1:0] PRESET = W'(LOAD_VAL);

  logic [W-1:0] nxt;

  generate
    if (MOD == (1 << W)) begin : g_pow2
      always_comb nxt = q + W'(1);
    end else begin : g_wrap
      always_comb nxt = (q == LAST) ? '0 : q + W'(1);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)        q <= '0;
    else if (load)  q <= PRESET;
    else if (clear) q <= '0;
    else if (step)  q <= nxt;
  end
endmodule

// File: rtl/dec_split_counter.sv
module dec_split_counter
  import dec_split_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            en_lo,
  input  logic            en_hi,
  input  logic            chain,
  input  logic            clr_a,
  input  logic            clr_b,
  input  logic            set9_a,
  input  logic            set9_b,
  output logic [LO_W-1:0] q_lo,
  output logic [HI_W-1:0] q_hi,
  output logic [OUT_W-1:0] bcd
);
  // nine = 4'b1001 : low stage 1, high stage (nine >> 1) = 4
  localparam int unsigned NINE = 9;
  localparam int unsigned LO_NINE = NINE % LO_MOD;
  localparam int unsigned HI_NINE = NINE / LO_MOD;

  stage_ctl_t ctl;

  dec_split_ctrl #(.LO_W(LO_W), .LO_MOD(LO_MOD)) i_ctrl (
    .en_lo(en_lo), .en_hi(en_hi), .chain(chain),
    .clr_a(clr_a), .clr_b(clr_b), .set9_a(set9_a), .set9_b(set9_b),
    .q_lo(q_lo), .ctl(ctl)
  );

  dec_split_stage #(.W(LO_W), .MOD(LO_MOD), .LOAD_VAL(LO_NINE)) i_lo (
    .clk(clk), .rst(rst), .load(ctl.load), .clear(ctl.clear),
    .step(ctl.step_lo), .q(q_lo)
  );

  dec_split_stage #(.W(HI_W), .MOD(HI_MOD), .LOAD_VAL(HI_NINE)) i_hi (
    .clk(clk), .rst(rst), .load(ctl.load), .clear(ctl.clear),
    .step(ctl.step_hi), .q(q_hi)
  );

  assign bcd = {q_hi, q_lo};
endmodule

// File: rtl/dec_split_counter_chk.sv
module dec_split_counter_chk (
  input logic       clk,
  input logic       rst,
  input logic       en_lo,
  input logic       en_hi,
  input logic       chain,
  input logic       clr_a,
  input logic       clr_b,
  input logic       set9_a,
  input logic       set9_b,
  input logic [0:0] q_lo,
  input logic [2:0] q_hi,
  input logic [3:0] bcd
);
  logic quiet;
  assign quiet = !(clr_a && clr_b) && !(set9_a && set9_b);

  p_lo_toggle_r2: assert property (@(posedge clk) disable iff (rst)
    (en_lo && quiet) |=> (q_lo != $past(q_lo)));

  p_lo_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (!en_lo && quiet) |=> $stable(q_lo));

  p_hi_idle_r3: assert property (@(posedge clk) disable iff (rst)
    (!chain && !en_hi && quiet) |=> $stable(q_hi));

  p_chain_carry_r4: assert property (@(posedge clk) disable iff (rst)
    (chain && en_lo && q_lo == 1'b1 && quiet) |=>
      (q_hi == (($past(q_hi) == 3'd4) ? 3'd0 : $past(q_hi) + 3'd1)));

  p_clear_r5: assert property (@(posedge clk) disable iff (rst)
    (clr_a && clr_b && !(set9_a && set9_b)) |=> (bcd == 4'd0));

  p_preset_r6: assert property (@(posedge clk) disable iff (rst)
    (set9_a && set9_b) |=> (bcd == 4'd9));

  p_range_r9: assert property (@(posedge clk) disable iff (rst)
    q_hi <= 3'd4);
endmodule

bind dec_split_counter dec_split_counter_chk i_chk (.*);

// File: tb/test_dec_split_counter.sv
`timescale 1ns/1ps
module test_dec_split_counter;
  logic clk = 1'b0;
  logic rst, en_lo, en_hi, chain, clr_a, clr_b, set9_a, set9_b;
  logic [0:0] q_lo;
  logic [2:0] q_hi;
  logic [3:0] bcd;

  int vectors = 0;
  int errors = 0;
  int m_lo = 0;
  int m_hi = 0;
  string tag = "R1";

  always #2.5 clk = ~clk;

  dec_split_counter i_dec_split_counter (
    .clk(clk), .rst(rst), .en_lo(en_lo), .en_hi(en_hi), .chain(chain),
    .clr_a(clr_a), .clr_b(clr_b), .set9_a(set9_a), .set9_b(set9_b),
    .q_lo(q_lo), .q_hi(q_hi), .bcd(bcd)
  );

  // behavioural reference, advanced once per rising edge
  task automatic model_step();
    bit hstep;
    if (rst) begin
      m_lo = 0; m_hi = 0;
    end else if (set9_a && set9_b) begin
      m_lo = 1; m_hi = 4;
    end else if (clr_a && clr_b) begin
      m_lo = 0; m_hi = 0;
    end else begin
      hstep = chain ? (en_lo && m_lo == 1) : en_hi;
      if (en_lo) m_lo = 1 - m_lo;
      if (hstep) m_hi = (m_hi == 4) ? 0 : m_hi + 1;
    end
  endtask

  task automatic cycle(input bit r, input bit el, input bit eh, input bit ch,
                       input bit ca, input bit cb, input bit sa, input bit sb);
    int exp_bcd;
    @(negedge clk);
    rst = r; en_lo = el; en_hi = eh; chain = ch;
    clr_a = ca; clr_b = cb; set9_a = sa; set9_b = sb;
    @(posedge clk);
    model_step();
    #1;
    exp_bcd = m_hi * 2 + m_lo;
    vectors++;
    if (bcd !== 4'(exp_bcd) || q_lo !== 1'(m_lo) || q_hi !== 3'(m_hi)) begin
      errors++;
      $display("FAIL %s: bcd=%0d q_lo=%0d q_hi=%0d expected bcd=%0d q_lo=%0d q_hi=%0d",
               tag, bcd, q_lo, q_hi, exp_bcd, m_lo, m_hi);
    end
    if (q_hi > 3'd4) begin
      errors++;
      $display("FAIL R9: q_hi=%0d expected <=4", q_hi);
    end
  endtask

  initial begin
    fork
      begin
        rst = 1; en_lo = 0; en_hi = 0; chain = 0;
        clr_a = 0; clr_b = 0; set9_a = 0; set9_b = 0;
        // R1: reset state, reset beats preset and enables
        tag = "R1";
        cycle(1, 0, 0, 0, 0, 0, 0, 0);
        cycle(1, 1, 1, 1, 0, 0, 1, 1);
        cycle(1, 0, 0, 0, 0, 0, 0, 0);
        // R2: one-bit stage toggle and hold
        tag = "R2";
        for (int i = 0; i < 6; i++) cycle(0, i % 3 != 2, 0, 0, 0, 0, 0, 0);
        // R3: independent five-state stage, wraps after 4, en_lo irrelevant
        tag = "R3";
        for (int i = 0; i < 14; i++) cycle(0, i[0], i % 4 != 3, 0, 0, 0, 0, 0);
        // R5: single clear has no effect, then pair clears
        tag = "R5";
        cycle(0, 0, 1, 0, 1, 0, 0, 0);
        cycle(0, 0, 0, 0, 0, 1, 0, 0);
        cycle(0, 0, 0, 0, 1, 1, 0, 0);
        // R4: chained decade, en_hi toggled and must be ignored, two full wraps
        tag = "R4";
        for (int i = 0; i < 24; i++) cycle(0, 1, i[0], 1, 0, 0, 0, 0);
        for (int i = 0; i < 8; i++) cycle(0, i % 3 != 0, 1, 1, 0, 0, 0, 0);
        // R6: single preset ignored, pair gives nine, then wrap 9 -> 0 chained
        tag = "R6";
        cycle(0, 0, 0, 1, 0, 0, 1, 0);
        cycle(0, 0, 0, 1, 0, 0, 0, 1);
        cycle(0, 0, 0, 1, 0, 0, 1, 1);
        cycle(0, 1, 0, 1, 0, 0, 0, 0);
        // R7: preset beats clear
        tag = "R7";
        cycle(0, 1, 1, 0, 1, 1, 1, 1);
        cycle(0, 0, 0, 0, 0, 0, 0, 0);
        // R8: overrides regardless of enables and chain
        tag = "R8";
        cycle(0, 1, 1, 1, 1, 1, 0, 0);
        cycle(0, 1, 1, 0, 0, 0, 1, 1);
        cycle(0, 1, 1, 0, 1, 1, 0, 0);
        // R9/R10: random mix, every output field compared each cycle
        tag = "R9";
        for (int i = 0; i < 400; i++) begin
          int r = $urandom;
          cycle((r % 97) == 0, r[1], r[2], r[3], r[4] & r[5], r[5],
                r[6] & r[7] & r[8], r[7]);
        end
        tag = "R10";
        for (int i = 0; i < 20; i++) cycle(0, 1, 0, 1, 0, 0, 0, 0);
      end
      begin
        repeat (5000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run=timeout expected=completion");
      end
    join_any
    disable fork;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule